// File: doc/BRIEF.md
# Translation Unit Register Write Decoder

This block is the write path of the memory-mapped register file of an I/O address-translation unit. A bus slave presents a byte offset, a 64-bit data word, an access size in bytes and a write strobe. The block clears offset bit 16 so that both 64 KB pages reach the same registers. It then decodes the offset, updates the addressed control, queue-pointer, interrupt-address or error-acknowledge register, and answers one cycle later with an OK or error response.

Several writes have side effects. A write to the main control register is mirrored, with its reserved bits cleared, into an acknowledge copy. A write to a queue base recomputes that queue's log2 size. A table-configuration write may latch a split value and set a sticky two-level-table feature bit. Writes that can unblock command processing emit a one-cycle kick to the command-queue consumer. The decoded sizes, the feature bit and all stored register values are driven out to the rest of the unit.

Top module: `xlat_regwr`

## Requirements
- R1: Offset bit 16 is ignored in decode. A write at offset X+0x10000 has the same effect and response as a write at offset X.
- R2: An access whose size is neither 4 nor 8 bytes gets `rsp_err`=1 and changes no register, and no kick is emitted.
- R3: A legal-size write to an offset with no register for that size changes nothing and gets `rsp_err`=0. A 32-bit register at the offset of an 8-byte access counts as no register. The 32-bit registers are: control 0x000, control-1 0x008, error-ack 0x040, table config 0x058, command producer 0x088, command consumer 0x08C, event producer 0x0A8 and event consumer 0x0AC. Each is written only by 4-byte accesses.
- R4: The 64-bit registers are at 0x048 (error IRQ address), 0x050 (table base), 0x080 (command queue base), 0x0A0 (event queue base) and 0x0B0 (event IRQ address). An 8-byte write at the base replaces all 64 bits. A 4-byte write at base+0 replaces bits [31:0], and one at base+4 replaces bits [63:32]. The other half keeps its value.
- R5: Any write that sets the low half of the command or event queue base loads that queue's log2 size from data bits [4:0], limited to CMDQ_MAX_LOG2 (default 19) or EVTQ_MAX_LOG2 (default 15). A write to the high half at base+4 leaves the size unchanged.
- R6: A write to the control register also loads `ctrl0_ack` with the written value ANDed with CTRL0_MASK (default 0x0000000D).
- R7: A write to table config stores the value. When bits [17:16] equal 1, bits [10:6] are latched into `tbl_split` and `feat_two_level` is set. It stays set until reset.
- R8: `cmdq_kick` pulses for one cycle after each legal write to the control register, the command producer or the error-ack register, and at no other time.
- R9: A write to error-ack inverts only the bits that differ between the written value and the current `err_ack` and that are also pending, where pending means `err_flags` differs from `err_ack`. All other bits keep their value.
- R10: A write strobed at clock edge N is answered by `rsp_valid`=1 after edge N+1's preceding edge, that is in the cycle after the strobe. The updated register values become visible in that same cycle.
- R11: Synchronous reset clears every register, size, feature bit and response output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_offset | input | OFS_W | Byte offset of the access |
| wr_size | input | 4 | Access size in bytes |
| wr_data | input | 64 | Write data; 4-byte accesses use bits [31:0] |
| err_flags | input | 32 | Current global error flags |
| rsp_valid | output | 1 | Response for the previous cycle's write |
| rsp_err | output | 1 | Response is an error (illegal size) |
| cmdq_kick | output | 1 | Command consumer re-scan pulse |
| ctrl0 | output | 32 | Control register |
| ctrl0_ack | output | 32 | Masked acknowledge copy of the control register |
| ctrl1 | output | 32 | Secondary control register |
| err_ack | output | 32 | Error acknowledge register |
| err_irq_addr | output | 64 | Error interrupt address |
| tbl_base | output | 64 | Stream table base |
| tbl_cfg | output | 32 | Stream table configuration |
| tbl_split | output | 5 | Latched split value |
| feat_two_level | output | 1 | Sticky two-level table feature |
| cmdq_base | output | 64 | Command queue base |
| cmdq_log2 | output | 5 | Command queue log2 size |
| cmdq_prod | output | 32 | Command queue producer index |
| cmdq_cons | output | 32 | Command queue consumer index |
| evtq_base | output | 64 | Event queue base |
| evtq_log2 | output | 5 | Event queue log2 size |
| evtq_prod | output | 32 | Event queue producer index |
| evtq_cons | output | 32 | Event queue consumer index |
| evt_irq_addr | output | 64 | Event interrupt address |

## Verification
The decoder is driven with 4-byte writes, 8-byte writes and illegal sizes of 0, 1 and 2 bytes. These separate the two legal decode paths from the error path. Split-half writes and whole writes to the same 64-bit register, some through the aliased page, show whether halves are preserved and whether bit 16 is dropped. Queue-base values above, below and at the high half show whether the size clamp is right and whether the high half can wrongly refresh the size. Error-ack writes are made with error flags that leave some bits pending and others not, which tells a correct toggle apart from a plain store or an unguarded toggle.

// File: rtl/xlat_regwr_pkg.sv
package xlat_regwr_pkg;

  localparam int NUM_WIDE = 5;

  // 32-bit register offsets (page-relative)
  localparam logic [15:0] OFS_CTRL0   = 16'h0000;
  localparam logic [15:0] OFS_CTRL1   = 16'h0008;
  localparam logic [15:0] OFS_ERR_ACK = 16'h0040;
  localparam logic [15:0] OFS_TBL_CFG = 16'h0058;
  localparam logic [15:0] OFS_CPROD   = 16'h0088;
  localparam logic [15:0] OFS_CCONS   = 16'h008C;
  localparam logic [15:0] OFS_EPROD   = 16'h00A8;
  localparam logic [15:0] OFS_ECONS   = 16'h00AC;

  // indices of the 64-bit registers
  localparam int WI_ERR_IRQ = 0;
  localparam int WI_TBASE   = 1;
  localparam int WI_CBASE   = 2;
  localparam int WI_EBASE   = 3;
  localparam int WI_EVT_IRQ = 4;

  // table config field positions
  localparam int FMT_LSB   = 16;
  localparam int SPLIT_LSB = 6;
  localparam int SPLIT_W   = 5;

  function automatic logic [15:0] wide_ofs(input int idx);
    case (idx)
      WI_ERR_IRQ: return 16'h0048;
      WI_TBASE:   return 16'h0050;
      WI_CBASE:   return 16'h0080;
      WI_EBASE:   return 16'h00A0;
      default:    return 16'h00B0;
    endcase
  endfunction

  typedef struct packed {
    logic                legal;
    logic                kick;
    logic                ctrl0;
    logic                ctrl1;
    logic                err_ack;
    logic                tbl_cfg;
    logic                cprod;
    logic                ccons;
    logic                eprod;
    logic                econs;
    logic [NUM_WIDE-1:0] lo;
    logic [NUM_WIDE-1:0] hi;
  } wsel_t;

endpackage

// File: rtl/xlat_regwr_decode.sv
module xlat_regwr_decode
  import xlat_regwr_pkg::*;
#(
  parameter int OFS_W = 17
) (
  input  logic             wr_en,
  input  logic [OFS_W-1:0] wr_offset,
  input  logic [3:0]       wr_size,
  output wsel_t            sel
);

  localparam logic [OFS_W-1:0] ALIAS_CLR = ~(OFS_W'(1) << 16);

  logic [OFS_W-1:0] a;
  logic             is4, is8;

  always_comb begin
    a   = wr_offset & ALIAS_CLR;
    is4 = (wr_size == 4'd4);
    is8 = (wr_size == 4'd8);
    sel = '0;
    sel.legal = wr_en && (is4 || is8);
    if (wr_en && is4) begin
      sel.ctrl0   = (a == OFS_W'(OFS_CTRL0));
      sel.ctrl1   = (a == OFS_W'(OFS_CTRL1));
      sel.err_ack = (a == OFS_W'(OFS_ERR_ACK));
      sel.tbl_cfg = (a == OFS_W'(OFS_TBL_CFG));
      sel.cprod   = (a == OFS_W'(OFS_CPROD));
      sel.ccons   = (a == OFS_W'(OFS_CCONS));
      sel.eprod   = (a == OFS_W'(OFS_EPROD));
      sel.econs   = (a == OFS_W'(OFS_ECONS));
      for (int i = 0; i < NUM_WIDE; i++) begin
        sel.lo[i] = (a == OFS_W'(wide_ofs(i)));
        sel.hi[i] = (a == OFS_W'(wide_ofs(i)) + OFS_W'(4));
      end
    end
    if (wr_en && is8) begin
      for (int i = 0; i < NUM_WIDE; i++) begin
        sel.lo[i] = (a == OFS_W'(wide_ofs(i)));
        sel.hi[i] = (a == OFS_W'(wide_ofs(i)));
      end
    end
    sel.kick = sel.ctrl0 | sel.cprod | sel.err_ack;
  end

endmodule

// File: rtl/xlat_wide_reg.sv
module xlat_wide_reg #(
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_lo,
  input  logic              we_hi,
  input  logic [HALF_W-1:0] lo_d,
  input  logic [HALF_W-1:0] hi_d,
  output logic [2*HALF_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      if (we_lo) q[HALF_W-1:0]        <= lo_d;
      if (we_hi) q[2*HALF_W-1:HALF_W] <= hi_d;
    end
  end

  // R4: a half that is not written keeps its value
  assert_keep_hi_R4: assert property (@(posedge clk) disable iff (rst)
    !we_hi |=> q[2*HALF_W-1:HALF_W] == $past(q[2*HALF_W-1:HALF_W]));
  assert_keep_lo_R4: assert property (@(posedge clk) disable iff (rst)
    !we_lo |=> q[HALF_W-1:0] == $past(q[HALF_W-1:0]));

endmodule

// File: rtl/xlat_err_ack.sv
module xlat_err_ack #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] err_flags,
  output logic [W-1:0] ack_q
);

  logic [W-1:0] flip;

  always_comb flip = (ack_q ^ wdata) & (err_flags ^ ack_q);

  always_ff @(posedge clk) begin
    if (rst)     ack_q <= '0;
    else if (we) ack_q <= ack_q ^ flip;
  end

  // R9: a bit only ever changes while it was pending
  assert_only_pending_R9: assert property (@(posedge clk) disable iff (rst)
    ((ack_q ^ $past(ack_q)) & ~($past(err_flags) ^ $past(ack_q))) == '0);

endmodule

// File: rtl/xlat_regwr.sv
module xlat_regwr
  import xlat_regwr_pkg::*;
#(
  parameter int          OFS_W         = 17,
  parameter int unsigned CMDQ_MAX_LOG2 = 19,
  parameter int unsigned EVTQ_MAX_LOG2 = 15,
  parameter logic [31:0] CTRL0_MASK    = 32'h0000_000D
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] wr_offset,
  input  logic [3:0]       wr_size,
  input  logic [63:0]      wr_data,
  input  logic [31:0]      err_flags,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic             cmdq_kick,
  output logic [31:0]      ctrl0,
  output logic [31:0]      ctrl0_ack,
  output logic [31:0]      ctrl1,
  output logic [31:0]      err_ack,
  output logic [63:0]      err_irq_addr,
  output logic [63:0]      tbl_base,
  output logic [31:0]      tbl_cfg,
  output logic [4:0]       tbl_split,
  output logic             feat_two_level,
  output logic [63:0]      cmdq_base,
  output logic [4:0]       cmdq_log2,
  output logic [31:0]      cmdq_prod,
  output logic [31:0]      cmdq_cons,
  output logic [63:0]      evtq_base,
  output logic [4:0]       evtq_log2,
  output logic [31:0]      evtq_prod,
  output logic [31:0]      evtq_cons,
  output logic [63:0]      evt_irq_addr
);

  localparam int HALF_W = 32;

  function automatic logic [4:0] clamp_log2(input logic [4:0] v, input int unsigned mx);
    if (32'(v) > mx) return 5'(mx);
    return v;
  endfunction

  wsel_t              sel;
  logic [HALF_W-1:0]  hi_data;
  logic [63:0]        wide_q [NUM_WIDE];

  xlat_regwr_decode #(.OFS_W(OFS_W)) u_dec (
    .wr_en(wr_en), .wr_offset(wr_offset), .wr_size(wr_size), .sel(sel)
  );

  // high half comes from the upper word on a whole write, the lower on a split one
  always_comb hi_data = (wr_size == 4'd8) ? wr_data[63:32] : wr_data[31:0];

  for (genvar g = 0; g < NUM_WIDE; g++) begin : g_wide
    xlat_wide_reg #(.HALF_W(HALF_W)) u_reg (
      .clk(clk), .rst(rst), .we_lo(sel.lo[g]), .we_hi(sel.hi[g]),
      .lo_d(wr_data[HALF_W-1:0]), .hi_d(hi_data), .q(wide_q[g])
    );
  end

  xlat_err_ack #(.W(32)) u_ack (
    .clk(clk), .rst(rst), .we(sel.err_ack), .wdata(wr_data[31:0]),
    .err_flags(err_flags), .ack_q(err_ack)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid      <= 1'b0;
      rsp_err        <= 1'b0;
      cmdq_kick      <= 1'b0;
      ctrl0          <= '0;
      ctrl0_ack      <= '0;
      ctrl1          <= '0;
      tbl_cfg        <= '0;
      tbl_split      <= '0;
      feat_two_level <= 1'b0;
      cmdq_log2      <= '0;
      evtq_log2      <= '0;
      cmdq_prod      <= '0;
      cmdq_cons      <= '0;
      evtq_prod      <= '0;
      evtq_cons      <= '0;
    end else begin
      rsp_valid <= wr_en;
      rsp_err   <= wr_en && !sel.legal;
      cmdq_kick <= sel.kick;
      if (sel.ctrl0) begin
        ctrl0     <= wr_data[31:0];
        ctrl0_ack <= wr_data[31:0] & CTRL0_MASK;
      end
      if (sel.ctrl1) ctrl1 <= wr_data[31:0];
      if (sel.tbl_cfg) begin
        tbl_cfg <= wr_data[31:0];
        if (wr_data[FMT_LSB+1:FMT_LSB] == 2'd1) begin
          tbl_split      <= wr_data[SPLIT_LSB+SPLIT_W-1:SPLIT_LSB];
          feat_two_level <= 1'b1;
        end
      end
      if (sel.lo[WI_CBASE]) cmdq_log2 <= clamp_log2(wr_data[4:0], CMDQ_MAX_LOG2);
      if (sel.lo[WI_EBASE]) evtq_log2 <= clamp_log2(wr_data[4:0], EVTQ_MAX_LOG2);
      if (sel.cprod) cmdq_prod <= wr_data[31:0];
      if (sel.ccons) cmdq_cons <= wr_data[31:0];
      if (sel.eprod) evtq_prod <= wr_data[31:0];
      if (sel.econs) evtq_cons <= wr_data[31:0];
    end
  end

  assign err_irq_addr = wide_q[WI_ERR_IRQ];
  assign tbl_base     = wide_q[WI_TBASE];
  assign cmdq_base    = wide_q[WI_CBASE];
  assign evtq_base    = wide_q[WI_EBASE];
  assign evt_irq_addr = wide_q[WI_EVT_IRQ];

  assert_rsp_follows_R10: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> rsp_valid);
  assert_kick_ok_rsp_R8: assert property (@(posedge clk) disable iff (rst)
    cmdq_kick |-> rsp_valid && !rsp_err);
  assert_bad_size_still_R2: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> $stable(ctrl0) && $stable(cmdq_prod) && $stable(cmdq_base)
                               && $stable(err_ack) && !cmdq_kick);
  assert_ack_mirror_R6: assert property (@(posedge clk) disable iff (rst)
    sel.ctrl0 |=> ctrl0_ack == (ctrl0 & CTRL0_MASK));
  assert_log2_limit_R5: assert property (@(posedge clk) disable iff (rst)
    (cmdq_log2 <= 5'(CMDQ_MAX_LOG2)) && (evtq_log2 <= 5'(EVTQ_MAX_LOG2)));
  assert_feat_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    feat_two_level |=> feat_two_level);

endmodule

// File: tb/xlat_regwr_test.sv
`timescale 1ns/1ps
module xlat_regwr_test;

  localparam int          CMAX = 19;
  localparam int          EMAX = 15;
  localparam logic [31:0] MASK = 32'h0000_000D;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [16:0] wr_offset = '0;
  logic [3:0]  wr_size = '0;
  logic [63:0] wr_data = '0;
  logic [31:0] err_flags = '0;

  logic        rsp_valid, rsp_err, cmdq_kick, feat_two_level;
  logic [31:0] ctrl0, ctrl0_ack, ctrl1, err_ack, tbl_cfg;
  logic [31:0] cmdq_prod, cmdq_cons, evtq_prod, evtq_cons;
  logic [63:0] err_irq_addr, tbl_base, cmdq_base, evtq_base, evt_irq_addr;
  logic [4:0]  tbl_split, cmdq_log2, evtq_log2;

  xlat_regwr uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_offset(wr_offset), .wr_size(wr_size),
    .wr_data(wr_data), .err_flags(err_flags), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .cmdq_kick(cmdq_kick), .ctrl0(ctrl0), .ctrl0_ack(ctrl0_ack), .ctrl1(ctrl1),
    .err_ack(err_ack), .err_irq_addr(err_irq_addr), .tbl_base(tbl_base), .tbl_cfg(tbl_cfg),
    .tbl_split(tbl_split), .feat_two_level(feat_two_level), .cmdq_base(cmdq_base),
    .cmdq_log2(cmdq_log2), .cmdq_prod(cmdq_prod), .cmdq_cons(cmdq_cons),
    .evtq_base(evtq_base), .evtq_log2(evtq_log2), .evtq_prod(evtq_prod),
    .evtq_cons(evtq_cons), .evt_irq_addr(evt_irq_addr)
  );

  always #2.5 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;

  // reference model state
  logic        e_valid, e_err, e_kick, e_feat;
  logic [31:0] m_c0, m_ack0, m_c1, m_eack, m_tcfg, m_cp, m_cc, m_ep, m_ec;
  logic [63:0] m_eirq, m_tb, m_cb, m_eb, m_virq;
  logic [4:0]  m_split, m_cl, m_el;
  logic        in_reset;

  function automatic logic [4:0] lim(input logic [4:0] v, input int mx);
    return (int'(v) > mx) ? 5'(mx) : v;
  endfunction

  function void chk(string tag, string name, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, name, act, exp);
    end
  endfunction

  task automatic model_step();
    logic [16:0] a;
    logic [31:0] d;
    a = wr_offset & 17'h0FFFF;
    d = wr_data[31:0];
    in_reset = rst;
    if (rst) begin
      e_valid = 0; e_err = 0; e_kick = 0; e_feat = 0;
      m_c0 = 0; m_ack0 = 0; m_c1 = 0; m_eack = 0; m_tcfg = 0;
      m_cp = 0; m_cc = 0; m_ep = 0; m_ec = 0;
      m_eirq = 0; m_tb = 0; m_cb = 0; m_eb = 0; m_virq = 0;
      m_split = 0; m_cl = 0; m_el = 0;
      return;
    end
    e_valid = wr_en;
    e_err   = wr_en && !(wr_size == 4 || wr_size == 8);
    e_kick  = 0;
    if (wr_en && wr_size == 4) begin
      case (a)
        17'h000: begin m_c0 = d; m_ack0 = d & MASK; e_kick = 1; end
        17'h008: m_c1 = d;
        17'h040: begin
          e_kick = 1;
          for (int b = 0; b < 32; b++)
            if (d[b] != m_eack[b] && err_flags[b] != m_eack[b]) m_eack[b] = ~m_eack[b];
        end
        17'h048: m_eirq[31:0] = d;
        17'h04C: m_eirq[63:32] = d;
        17'h050: m_tb[31:0] = d;
        17'h054: m_tb[63:32] = d;
        17'h058: begin
          m_tcfg = d;
          if (d[17:16] == 2'd1) begin m_split = d[10:6]; e_feat = 1; end
        end
        17'h080: begin m_cb[31:0] = d; m_cl = lim(d[4:0], CMAX); end
        17'h084: m_cb[63:32] = d;
        17'h088: begin m_cp = d; e_kick = 1; end
        17'h08C: m_cc = d;
        17'h0A0: begin m_eb[31:0] = d; m_el = lim(d[4:0], EMAX); end
        17'h0A4: m_eb[63:32] = d;
        17'h0A8: m_ep = d;
        17'h0AC: m_ec = d;
        17'h0B0: m_virq[31:0] = d;
        17'h0B4: m_virq[63:32] = d;
        default: ;
      endcase
    end else if (wr_en && wr_size == 8) begin
      case (a)
        17'h048: m_eirq = wr_data;
        17'h050: m_tb = wr_data;
        17'h080: begin m_cb = wr_data; m_cl = lim(d[4:0], CMAX); end
        17'h0A0: begin m_eb = wr_data; m_el = lim(d[4:0], EMAX); end
        17'h0B0: m_virq = wr_data;
        default: ;
      endcase
    end
  endtask

  task automatic compare();
    string t;
    t = in_reset ? "R11" : "";
    chk(in_reset ? t : "R10", "rsp_valid", 64'(rsp_valid), 64'(e_valid));
    chk(in_reset ? t : "R2",  "rsp_err", 64'(rsp_err), 64'(e_err));
    chk(in_reset ? t : "R8",  "cmdq_kick", 64'(cmdq_kick), 64'(e_kick));
    chk(in_reset ? t : "R1",  "ctrl0", 64'(ctrl0), 64'(m_c0));
    chk(in_reset ? t : "R6",  "ctrl0_ack", 64'(ctrl0_ack), 64'(m_ack0));
    chk(in_reset ? t : "R3",  "ctrl1", 64'(ctrl1), 64'(m_c1));
    chk(in_reset ? t : "R9",  "err_ack", 64'(err_ack), 64'(m_eack));
    chk(in_reset ? t : "R4",  "err_irq_addr", err_irq_addr, m_eirq);
    chk(in_reset ? t : "R4",  "tbl_base", tbl_base, m_tb);
    chk(in_reset ? t : "R7",  "tbl_cfg", 64'(tbl_cfg), 64'(m_tcfg));
    chk(in_reset ? t : "R7",  "tbl_split", 64'(tbl_split), 64'(m_split));
    chk(in_reset ? t : "R7",  "feat_two_level", 64'(feat_two_level), 64'(e_feat));
    chk(in_reset ? t : "R4",  "cmdq_base", cmdq_base, m_cb);
    chk(in_reset ? t : "R5",  "cmdq_log2", 64'(cmdq_log2), 64'(m_cl));
    chk(in_reset ? t : "R3",  "cmdq_prod", 64'(cmdq_prod), 64'(m_cp));
    chk(in_reset ? t : "R3",  "cmdq_cons", 64'(cmdq_cons), 64'(m_cc));
    chk(in_reset ? t : "R4",  "evtq_base", evtq_base, m_eb);
    chk(in_reset ? t : "R5",  "evtq_log2", 64'(evtq_log2), 64'(m_el));
    chk(in_reset ? t : "R3",  "evtq_prod", 64'(evtq_prod), 64'(m_ep));
    chk(in_reset ? t : "R3",  "evtq_cons", 64'(evtq_cons), 64'(m_ec));
    chk(in_reset ? t : "R1",  "evt_irq_addr", evt_irq_addr, m_virq);
  endtask

  // model advances on each edge; outputs sampled 1 ns later
  always @(posedge clk) begin
    model_step();
    #1;
    compare();
  end

  task automatic wr(input logic [16:0] ofs, input logic [3:0] sz, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_offset = ofs; wr_size = sz; wr_data = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
    end
  endtask

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 20000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(1);
    // R6 / R8: control write, reserved bits masked, kick
    wr(17'h00000, 4, 64'hFFFF_FFFF_FFFF_FFFF);
    idle(1);
    // R1: alias page
    wr(17'h10000, 4, 64'h0000_0012);
    wr(17'h10008, 4, 64'h0000_ABCD);
    // R3: 8-byte to 32-bit reg and unmapped offsets ignored
    wr(17'h00008, 8, 64'h1111_2222_3333_4444);
    wr(17'h00300, 4, 64'h5555_6666);
    wr(17'h0004C, 8, 64'h7777_8888_9999_AAAA);
    // R2: illegal sizes
    wr(17'h00000, 2, 64'h0000_0001);
    wr(17'h00088, 1, 64'h0000_0009);
    wr(17'h00040, 0, 64'hFFFF_FFFF);
    idle(1);
    // R4 / R5: queue bases
    wr(17'h00080, 8, 64'hDEAD_BEEF_0000_001F);
    wr(17'h00084, 4, 64'h0000_1234);
    wr(17'h00080, 4, 64'h0000_0005);
    wr(17'h000A0, 4, 64'h0000_001E);
    wr(17'h000A0, 8, 64'hCAFE_0000_0000_0003);
    wr(17'h100A4, 4, 64'h0000_00FF);
    wr(17'h000A0, 4, 64'h0000_000F);
    wr(17'h00048, 4, 64'h0000_1000);
    wr(17'h0004C, 4, 64'h0000_0002);
    wr(17'h00050, 8, 64'h0123_4567_89AB_CDEF);
    wr(17'h100B0, 8, 64'hFEDC_BA98_7654_3210);
    wr(17'h000B4, 4, 64'h0000_0BAD);
    idle(2);
    // R7: table config
    wr(17'h00058, 4, 64'h0000_01C0);
    wr(17'h00058, 4, 64'h0001_01C0);
    wr(17'h00058, 4, 64'h0002_00C0);
    // R8: producer kicks, consumer does not
    wr(17'h00088, 4, 64'h0000_0004);
    wr(17'h0008C, 4, 64'h0000_0002);
    wr(17'h000A8, 4, 64'h0000_0003);
    wr(17'h000AC, 4, 64'h0000_0001);
    idle(1);
    // R9: toggle acknowledge
    err_flags = 32'h0000_000F;
    wr(17'h00040, 4, 64'h0000_00FF);
    wr(17'h00040, 4, 64'h0000_0000);
    idle(1);
    err_flags = 32'h0000_0005;
    wr(17'h10040, 4, 64'h0000_0000);
    idle(1);
    err_flags = 32'h0000_0030;
    wr(17'h00040, 4, 64'h0000_0010);
    wr(17'h00040, 4, 64'h0000_0035);
    idle(3);
    // R11: reset clears everything
    @(negedge clk); rst = 1'b1;
    idle(2);
    @(negedge clk); rst = 1'b0;
    idle(2);
    finish_run();
  end

endmodule